// File: doc/BRIEF.md
# Interrupt Redirection and Delivery Core

This block turns a set of external interrupt input pins into interrupt delivery messages. Each pin owns one 64-bit redirection entry. The entry chooses the vector, the delivery mode, the destination and destination mode, the polarity, edge or level triggering, and a mask. The block records pending requests for each pin and picks the lowest-numbered unmasked pending pin. It sends one message for that pin on a valid/ready output.

Level-triggered pins use a remote-IRR handshake. Once a level pin is delivered, it is held off until an end-of-interrupt broadcast carries the matching vector. If the line is still high at that point, the pin is delivered again. Entries are loaded whole through a single write port. A pin whose delivery mode selects an external legacy controller takes its vector from a request/acknowledge stub instead of from its entry.

Top module: `irq_route`

## Requirements
- R1: After reset every entry is masked and nothing is pending, so no input activity produces a message until an entry is written unmasked.
- R2: On an unmasked edge-triggered pin, a low-to-high input change produces exactly one message. Holding the input high produces no further message.
- R3: A rising input on a masked edge-triggered pin is discarded. Clearing the mask later produces no message for that rise.
- R4: A delivered level-triggered pin sets its remote-IRR bit. While that bit is set, no further message is sent for the pin, even if its input stays high.
- R5: An end-of-interrupt with vector V clears remote-IRR on every entry whose vector equals V. If such a pin is unmasked and its input is still high, it is delivered again. A non-matching vector changes nothing.
- R6: The pending state of a level pin follows its input whatever the mask. A masked pin held high is not delivered, and it is delivered once its mask is cleared.
- R7: When several pins are eligible, the lowest-numbered pin is delivered first, and at most one message is accepted per clock.
- R8: While msg_valid is high and msg_ready is low, the message holds all its fields unchanged.
- R9: With delivery mode 3'b111, the block raises ext_req and keeps msg_valid low. On ext_ack it sends the message with the vector taken from ext_vec.
- R10: The entry layout is as follows. Bits [7:0] hold the vector, [10:8] the delivery mode, bit 11 the destination mode (1 = logical), bit 13 the polarity, bit 15 the trigger mode (1 = level), bit 16 the mask, and [63:56] the destination. The message copies every one of these fields, along with the pin number.
- R11: Bits 12 and 14 of a written entry are ignored. A write keeps the remote-IRR state, except that writing an edge-triggered entry clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N | Interrupt input pins |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDX_W | Entry index to write |
| wr_data | input | 64 | Entry value |
| eoi_valid | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vec | input | 8 | Vector carried by the broadcast |
| ext_req | output | 1 | Request to the legacy vector source |
| ext_ack | input | 1 | Legacy vector is valid |
| ext_vec | input | 8 | Legacy vector |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_pin | output | IDX_W | Pin being delivered |
| msg_vector | output | 8 | Vector |
| msg_dlv_mode | output | 3 | Delivery mode |
| msg_dest | output | 8 | Destination |
| msg_dest_logical | output | 1 | Destination mode |
| msg_polarity | output | 1 | Pin polarity |
| msg_trig_level | output | 1 | Trigger mode, 1 = level |

## Verification
The bench targets the cases where a slip produces a stray or a missing message:
- A rise on a masked edge pin. A design that latched it regardless of the mask would deliver it as soon as the mask was cleared.
- A level pin held high with remote-IRR set. A design without the handshake would resend the pin every cycle. The bench also sends a non-matching end-of-interrupt; a design that cleared remote-IRR on any vector would redeliver.
- Rewriting a delivered level pin as edge and then back to level. This must re-arm the pin, and a value of 1 in the written remote-IRR bit must not suppress it.
- Simultaneous requests, a stalled consumer and the legacy-vector handshake. These expose wrong priority order, a message that changes under back-pressure, and a message sent before the external vector arrives.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int ENT_W    = 64;
  localparam int VEC_W    = 8;
  localparam int DM_W     = 3;
  localparam int DEST_W   = 8;

  localparam int VEC_LSB  = 0;
  localparam int DM_LSB   = 8;
  localparam int DMOD_BIT = 11;
  localparam int POL_BIT  = 13;
  localparam int TRIG_BIT = 15;
  localparam int MASK_BIT = 16;
  localparam int DEST_LSB = 56;

  localparam logic [DM_W-1:0] DM_LEGACY = 3'b111;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              mask;
    logic              lvl;
    logic              pol;
    logic              dlog;
    logic [DM_W-1:0]   dm;
    logic [VEC_W-1:0]  vec;
  } rte_t;

  localparam rte_t RTE_RESET = '{dest: '0, mask: 1'b1, lvl: 1'b0, pol: 1'b0,
                                 dlog: 1'b0, dm: '0, vec: '0};

  typedef enum logic {ST_IDLE, ST_EXT} dlv_state_t;

  function automatic rte_t rte_decode(input logic [ENT_W-1:0] d);
    rte_t r;
    r.vec  = d[VEC_LSB +: VEC_W];
    r.dm   = d[DM_LSB +: DM_W];
    r.dlog = d[DMOD_BIT];
    r.pol  = d[POL_BIT];
    r.lvl  = d[TRIG_BIT];
    r.mask = d[MASK_BIT];
    r.dest = d[DEST_LSB +: DEST_W];
    return r;
  endfunction

endpackage

// File: rtl/irq_route_table.sv
module irq_route_table
  import irq_route_pkg::*;
#(
  parameter int N     = 24,
  parameter int IDX_W = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [ENT_W-1:0]     wr_data,
  input  logic                 svc_fire,
  input  logic [IDX_W-1:0]     svc_idx,
  input  logic                 svc_level,
  input  logic                 eoi_valid,
  input  logic [VEC_W-1:0]     eoi_vec,
  output rte_t                 cfg [N],
  output logic [N-1:0]         rirr
);

  rte_t         wr_cfg;
  logic [N-1:0] rirr_nxt;

  assign wr_cfg = rte_decode(wr_data);

  always_comb begin
    for (int i = 0; i < N; i++) begin
      rirr_nxt[i] = rirr[i];
      if (eoi_valid && rirr[i] && (cfg[i].vec == eoi_vec))
        rirr_nxt[i] = 1'b0;
      if (svc_fire && svc_level && (svc_idx == IDX_W'(i)))
        rirr_nxt[i] = 1'b1;
      if (wr_en && (wr_idx == IDX_W'(i)) && !wr_cfg.lvl)
        rirr_nxt[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) cfg[i] <= RTE_RESET;
      rirr <= '0;
    end else begin
      for (int i = 0; i < N; i++)
        if (wr_en && (wr_idx == IDX_W'(i))) cfg[i] <= wr_cfg;
      rirr <= rirr_nxt;
    end
  end

endmodule

// File: rtl/irq_route_pend.sv
module irq_route_pend #(
  parameter int N     = 24,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     irq_in,
  input  logic [N-1:0]     mask_vec,
  input  logic [N-1:0]     level_vec,
  input  logic             svc_fire,
  input  logic [IDX_W-1:0] svc_idx,
  output logic [N-1:0]     pend
);

  logic [N-1:0] irq_q;
  logic [N-1:0] rise;

  assign rise = irq_in & ~irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= '0;
      pend  <= '0;
    end else begin
      irq_q <= irq_in;
      for (int i = 0; i < N; i++) begin
        if (level_vec[i]) begin
          pend[i] <= irq_in[i];
        end else if (rise[i] && !mask_vec[i]) begin
          pend[i] <= 1'b1;
        end else if (svc_fire && (svc_idx == IDX_W'(i))) begin
          pend[i] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/irq_route_pick.sv
module irq_route_pick #(
  parameter int N     = 24,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) idx = IDX_W'(i);
  end

endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_route_pkg::*;
#(
  parameter int N     = 24,
  parameter int IDX_W = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         irq_in,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [63:0]          wr_data,
  input  logic                 eoi_valid,
  input  logic [7:0]           eoi_vec,
  output logic                 ext_req,
  input  logic                 ext_ack,
  input  logic [7:0]           ext_vec,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [IDX_W-1:0]     msg_pin,
  output logic [7:0]           msg_vector,
  output logic [2:0]           msg_dlv_mode,
  output logic [7:0]           msg_dest,
  output logic                 msg_dest_logical,
  output logic                 msg_polarity,
  output logic                 msg_trig_level
);

  rte_t             cfg [N];
  logic [N-1:0]     rirr_vec;
  logic [N-1:0]     pend_vec;
  logic [N-1:0]     mask_vec;
  logic [N-1:0]     level_vec;
  logic [N-1:0]     elig;
  logic             found;
  logic [IDX_W-1:0] sel_idx;
  rte_t             sel_cfg;
  logic             sel_level;
  logic             can_take;
  logic             svc_fire;
  dlv_state_t       st;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      mask_vec[i]  = cfg[i].mask;
      level_vec[i] = cfg[i].lvl;
    end
  end

  assign elig = pend_vec & ~mask_vec & ~(level_vec & rirr_vec);

  irq_route_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .req   (elig),
    .found (found),
    .idx   (sel_idx)
  );

  always_comb begin
    sel_cfg = RTE_RESET;
    for (int i = 0; i < N; i++)
      if (sel_idx == IDX_W'(i)) sel_cfg = cfg[i];
  end

  assign sel_level = sel_cfg.lvl;
  assign can_take  = (st == ST_IDLE) && (!msg_valid || msg_ready);
  assign svc_fire  = can_take && found;

  irq_route_table #(.N(N), .IDX_W(IDX_W)) u_tab (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .svc_fire  (svc_fire),
    .svc_idx   (sel_idx),
    .svc_level (sel_level),
    .eoi_valid (eoi_valid),
    .eoi_vec   (eoi_vec),
    .cfg       (cfg),
    .rirr      (rirr_vec)
  );

  irq_route_pend #(.N(N), .IDX_W(IDX_W)) u_pend (
    .clk       (clk),
    .rst       (rst),
    .irq_in    (irq_in),
    .mask_vec  (mask_vec),
    .level_vec (level_vec),
    .svc_fire  (svc_fire),
    .svc_idx   (sel_idx),
    .pend      (pend_vec)
  );

  assign ext_req = (st == ST_EXT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st               <= ST_IDLE;
      msg_valid        <= 1'b0;
      msg_pin          <= '0;
      msg_vector       <= '0;
      msg_dlv_mode     <= '0;
      msg_dest         <= '0;
      msg_dest_logical <= 1'b0;
      msg_polarity     <= 1'b0;
      msg_trig_level   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (svc_fire) begin
            msg_pin          <= sel_idx;
            msg_vector       <= sel_cfg.vec;
            msg_dlv_mode     <= sel_cfg.dm;
            msg_dest         <= sel_cfg.dest;
            msg_dest_logical <= sel_cfg.dlog;
            msg_polarity     <= sel_cfg.pol;
            msg_trig_level   <= sel_cfg.lvl;
            if (sel_cfg.dm == DM_LEGACY) begin
              st        <= ST_EXT;
              msg_valid <= 1'b0;
            end else begin
              msg_valid <= 1'b1;
            end
          end else if (msg_valid && msg_ready) begin
            msg_valid <= 1'b0;
          end
        end
        ST_EXT: begin
          if (ext_ack) begin
            msg_vector <= ext_vec;
            msg_valid  <= 1'b1;
            st         <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int N     = 24,
  parameter int IDX_W = $clog2(N)
) (
  input logic             clk,
  input logic             rst,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [IDX_W-1:0] msg_pin,
  input logic [7:0]       msg_vector,
  input logic             ext_req,
  input logic             svc_fire,
  input logic [IDX_W-1:0] sel_idx,
  input logic             sel_level,
  input logic [N-1:0]     irq_in,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [N-1:0]     rirr_vec,
  input logic [N-1:0]     pend_vec
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !msg_valid); // R1

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_pin)); // R8

  AST_EXT_QUIET: assert property (@(posedge clk) disable iff (rst)
    ext_req |-> !msg_valid); // R9

  AST_LEVEL_ARM: assert property (@(posedge clk) disable iff (rst)
    svc_fire && sel_level && !(wr_en && wr_idx == sel_idx) |=> rirr_vec[$past(sel_idx)]); // R4

  AST_EDGE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    svc_fire && !sel_level && !irq_in[sel_idx] |=> !pend_vec[$past(sel_idx)]); // R2

endmodule

bind irq_route irq_route_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .msg_valid  (msg_valid),
  .msg_ready  (msg_ready),
  .msg_pin    (msg_pin),
  .msg_vector (msg_vector),
  .ext_req    (ext_req),
  .svc_fire   (svc_fire),
  .sel_idx    (sel_idx),
  .sel_level  (sel_level),
  .irq_in     (irq_in),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .rirr_vec   (rirr_vec),
  .pend_vec   (pend_vec)
);

// File: tb/sim_irq_route.sv
`timescale 1ns/1ps
module sim_irq_route;

  localparam int N     = 24;
  localparam int IDX_W = $clog2(N);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [N-1:0]     irq_in = '0;
  logic             wr_en = 1'b0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic [63:0]      wr_data = '0;
  logic             eoi_valid = 1'b0;
  logic [7:0]       eoi_vec = '0;
  logic             ext_req;
  logic             ext_ack = 1'b0;
  logic [7:0]       ext_vec = '0;
  logic             msg_valid;
  logic             msg_ready = 1'b0;
  logic [IDX_W-1:0] msg_pin;
  logic [7:0]       msg_vector;
  logic [2:0]       msg_dlv_mode;
  logic [7:0]       msg_dest;
  logic             msg_dest_logical;
  logic             msg_polarity;
  logic             msg_trig_level;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_route #(.N(N)) u0 (.*);

  function automatic logic [63:0] mk(input logic [7:0] vec, input logic [2:0] dm,
                                     input logic dlog, input logic pol, input logic lvl,
                                     input logic msk, input logic [7:0] dest);
    logic [63:0] d = '0;
    d[7:0] = vec; d[10:8] = dm; d[11] = dlog; d[13] = pol;
    d[15] = lvl; d[16] = msk; d[63:56] = dest;
    return d;
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [63:0] d);
    @(negedge clk); wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic eoi(input logic [7:0] v);
    @(negedge clk); eoi_valid = 1'b1; eoi_vec = v;
    @(negedge clk); eoi_valid = 1'b0;
  endtask

  task automatic consume();
    msg_ready = 1'b1;
    @(negedge clk); msg_ready = 1'b0;
  endtask

  task automatic wait_msg(input int pin, input int vec, input string tag, input logic take);
    int n = 0;
    while (!msg_valid && n < 20) begin @(negedge clk); n++; end
    chk(msg_valid, {tag, " valid"}, int'(msg_valid), 1);
    chk(msg_pin == IDX_W'(pin), {tag, " pin"}, int'(msg_pin), pin);
    chk(msg_vector == 8'(vec), {tag, " vector"}, int'(msg_vector), vec);
    if (take) consume();
  endtask

  task automatic expect_none(input int cyc, input string tag);
    logic seen = 1'b0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (msg_valid) seen = 1'b1;
    end
    chk(!seen, tag, int'(seen), 0);
  endtask

  task automatic t_reset();
    chk(!msg_valid && !ext_req, "R1 reset outputs", int'({msg_valid, ext_req}), 0);
    @(negedge clk); irq_in = '1;
    @(negedge clk); irq_in = '0;
    expect_none(6, "R1 masked after reset");
  endtask

  task automatic t_edge_fields();
    wr(1, mk(8'h21, 3'b001, 1'b1, 1'b1, 1'b0, 1'b0, 8'h80));
    @(negedge clk); irq_in[1] = 1'b1;
    wait_msg(1, 8'h21, "R2 edge", 1'b0);
    chk(msg_dlv_mode == 3'b001 && msg_dest == 8'h80 && msg_dest_logical &&
        msg_polarity && !msg_trig_level, "R10 fields",
        int'({msg_dlv_mode, msg_dest, msg_dest_logical, msg_polarity, msg_trig_level}),
        int'({3'b001, 8'h80, 1'b1, 1'b1, 1'b0}));
    consume();
    expect_none(8, "R2 held high no repeat");
    irq_in[1] = 1'b0;
  endtask

  task automatic t_masked_edge();
    wr(4, mk(8'h44, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01));
    @(negedge clk); irq_in[4] = 1'b1;
    @(negedge clk); irq_in[4] = 1'b0;
    expect_none(4, "R3 masked edge");
    wr(4, mk(8'h44, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01));
    expect_none(6, "R3 unmask after drop");
  endtask

  task automatic t_level_eoi();
    wr(7, mk(8'h41, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 8'h02));
    @(negedge clk); irq_in[7] = 1'b1;
    wait_msg(7, 8'h41, "R4 level first", 1'b0);
    chk(msg_trig_level, "R10 trig level", int'(msg_trig_level), 1);
    consume();
    expect_none(8, "R4 remote-IRR holds off");
    eoi(8'h40);
    expect_none(6, "R5 non-matching eoi");
    eoi(8'h41);
    wait_msg(7, 8'h41, "R5 redeliver after eoi", 1'b1);
    expect_none(4, "R4 held off again");
  endtask

  task automatic t_rewrite_rearm();
    wr(7, mk(8'h41, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 8'h02));
    wr(7, mk(8'h41, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 8'h02) | (64'h1 << 14));
    wait_msg(7, 8'h41, "R11 edge rewrite rearms", 1'b1);
    @(negedge clk); irq_in[7] = 1'b0;
    eoi(8'h41);
    expect_none(4, "R5 eoi with line low");
  endtask

  task automatic t_level_masked();
    wr(2, mk(8'h52, 3'b000, 1'b0, 1'b0, 1'b1, 1'b1, 8'h03));
    @(negedge clk); irq_in[2] = 1'b1;
    expect_none(6, "R6 masked level");
    wr(2, mk(8'h52, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 8'h03));
    wait_msg(2, 8'h52, "R6 unmask delivers", 1'b1);
    irq_in[2] = 1'b0;
    eoi(8'h52);
  endtask

  task automatic t_priority();
    wr(3, mk(8'h33, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h04));
    wr(9, mk(8'h39, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h04));
    @(negedge clk); irq_in[3] = 1'b1; irq_in[9] = 1'b1;
    @(negedge clk); irq_in[3] = 1'b0; irq_in[9] = 1'b0;
    wait_msg(3, 8'h33, "R7 lowest first", 1'b0);
    repeat (3) @(negedge clk);
    chk(msg_valid && msg_pin == 5'd3 && msg_vector == 8'h33, "R8 stall holds",
        int'(msg_pin), 3);
    consume();
    wait_msg(9, 8'h39, "R7 next pin", 1'b1);
    expect_none(4, "R7 no extra");
  endtask

  task automatic t_legacy();
    int n = 0;
    wr(5, mk(8'h00, 3'b111, 1'b0, 1'b0, 1'b0, 1'b0, 8'h05));
    @(negedge clk); irq_in[5] = 1'b1;
    @(negedge clk); irq_in[5] = 1'b0;
    while (!ext_req && n < 20) begin @(negedge clk); n++; end
    chk(ext_req, "R9 ext_req raised", int'(ext_req), 1);
    repeat (2) @(negedge clk);
    chk(!msg_valid && ext_req, "R9 waits for ack", int'(msg_valid), 0);
    ext_ack = 1'b1; ext_vec = 8'h5A;
    @(negedge clk); ext_ack = 1'b0;
    chk(!ext_req, "R9 ext_req dropped", int'(ext_req), 0);
    wait_msg(5, 8'h5A, "R9 legacy vector", 1'b0);
    chk(msg_dlv_mode == 3'b111, "R9 mode", int'(msg_dlv_mode), 7);
    consume();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_edge_fields();
    t_masked_edge();
    t_level_eoi();
    t_rewrite_rearm();
    t_level_masked();
    t_priority();
    t_legacy();
    summary();
  end

endmodule